// File: doc/BRIEF.md
# Programmable Multiple Pulse Generator

This block produces a burst of between 0 and 99 clean output pulses. The burst length comes from two static BCD digit inputs, one for tens and one for units. Each pulse is as wide as the high phase of the system clock. One whole idle clock separates each pulse from the next, so the pulses are evenly spaced. A single-cycle Start request made while the block is idle captures the digits and launches the burst. The done output stays high whenever the block is idle and ready for a new request.

The count is held in a chain of BCD down-counters that update on the rising clock edge. The units digit wraps from 0 to 9 and drives its active-low borrow-out low, which steps the tens digit. A small sequencer updates on the falling clock edge and walks through load, fire and gap. The output pulse is the sequencer's registered fire state ANDed with the clock. That state only changes while the clock is low, so the pulse cannot glitch and is exactly one high phase wide.

Top module: `pulse_train_gen`

## Requirements
- R1: While rst_n is low, and straight after it rises, done is 1, pulse is 0 and the count is 00.
- R2: If start is high at a falling clock edge while the block is idle, the digits are captured at the next rising edge. When the setting is nonzero, the first pulse appears in the high phase of the second clock after the one in which start was raised.
- R3: A setting of tens T and units U (T, U in 0..9) produces exactly 10*T+U pulses and then stops.
- R4: pulse is high only during the high phase of the clock and is 0 during every low phase.
- R5: Pulses come every 2 clocks: a clock with a pulse is always followed by a clock without one.
- R6: A setting of 00 produces no pulse, and done is high again in the second clock after the start clock.
- R7: A digit input above 9 is loaded as 9.
- R8: start, and any change on the digit inputs, has no effect while a burst is in progress. The burst keeps the count captured at launch.
- R9: Both digits always hold BCD values (0..9). Each decrement lowers the two-digit value by exactly one, with the units digit wrapping from 0 to 9 and borrowing from tens. The chain never underflows.
- R10: done goes low in the first clock after the start clock. It returns high in clock 2N+2 counted from the start clock, where N is the pulse count, and only once the count has reached 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counters use the rising edge, the sequencer the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset for counters and sequencer |
| start | input | 1 | Launch request, sampled on the falling edge while idle |
| tens_in | input | 4 | Tens digit of the pulse count (BCD; values above 9 act as 9) |
| units_in | input | 4 | Units digit of the pulse count (BCD; values above 9 act as 9) |
| pulse | output | 1 | Output pulse train, one clock high phase wide per pulse |
| done | output | 1 | High while idle and ready for a new start |

## Verification
Clock k is the clock whose high phase carries the start request. The sequencer sees start at the falling edge of clock k and the digits load at rising edge k+1. For a count N, pulses are due in the high phases of clocks k+2, k+4, up to k+2N, and done returns in clock k+2N+2. The bench samples 5 ns into each high phase and 5 ns into each low phase, well away from both edges. At each sample it compares pulse and done against the slot formula above, and every low-phase sample must show pulse at 0.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_FIRE = 2'd2,
    ST_GAP  = 2'd3
  } pg_state_e;

  localparam int unsigned DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

  // Saturate an out-of-range BCD digit to 9.
  function automatic logic [DIGIT_W-1:0] bcd_clamp(input logic [DIGIT_W-1:0] d);
    return (d > DIGIT_MAX) ? DIGIT_MAX : d;
  endfunction

  // One BCD down step, wrapping 0 to 9.
  function automatic logic [DIGIT_W-1:0] bcd_step_down(input logic [DIGIT_W-1:0] d);
    return (d == '0) ? DIGIT_MAX : d - 1'b1;
  endfunction

endpackage

// File: rtl/pgen_bcd_digit.sv
module pgen_bcd_digit
  import pgen_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DIGIT_W-1:0] load_val,
  input  logic               dec_en,
  output logic [DIGIT_W-1:0] value,
  output logic               borrow_n,
  output logic               is_zero
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value <= '0;
    else if (load)    value <= bcd_clamp(load_val);
    else if (dec_en)  value <= bcd_step_down(value);
  end

  assign is_zero  = (value == '0);
  assign borrow_n = ~(dec_en & is_zero);

endmodule

// File: rtl/pgen_bcd_chain.sv
module pgen_bcd_chain
  import pgen_pkg::*;
#(
  parameter int unsigned DIGITS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [DIGITS*DIGIT_W-1:0]   load_digits,
  input  logic                        dec,
  output logic [DIGITS*DIGIT_W-1:0]   digits,
  output logic                        all_zero,
  output logic                        chain_borrow_n
);

  logic [DIGITS:0]   step_en;
  logic [DIGITS-1:0] bn;
  logic [DIGITS-1:0] zero;

  assign step_en[0] = dec;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    pgen_bcd_digit u_digit (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_digits[i*DIGIT_W +: DIGIT_W]),
      .dec_en   (step_en[i]),
      .value    (digits[i*DIGIT_W +: DIGIT_W]),
      .borrow_n (bn[i]),
      .is_zero  (zero[i])
    );
    assign step_en[i+1] = ~bn[i];
  end

  assign all_zero       = &zero;
  assign chain_borrow_n = ~step_en[DIGITS];

endmodule

// File: rtl/pgen_ctrl.sv
module pgen_ctrl
  import pgen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic all_zero,
  output logic fire_st,
  output logic load_st,
  output logic idle_st
);

  pg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_LOAD;
      ST_LOAD: state_d = all_zero ? ST_IDLE : ST_FIRE;
      ST_FIRE: state_d = ST_GAP;
      ST_GAP:  state_d = all_zero ? ST_IDLE : ST_FIRE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Falling-edge sequencer: state settles while clk is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign fire_st = (state_q == ST_FIRE);
  assign load_st = (state_q == ST_LOAD);
  assign idle_st = (state_q == ST_IDLE);

endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen
  import pgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] tens_in,
  input  logic [3:0] units_in,
  output logic       pulse,
  output logic       done
);

  localparam int unsigned NDIG = 2;

  logic                    fire_st, load_st, idle_st;
  logic                    all_zero, chain_borrow_n;
  logic [NDIG*DIGIT_W-1:0] cnt_digits;
  logic [DIGIT_W-1:0]      tens_q, units_q;

  pgen_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .all_zero (all_zero),
    .fire_st  (fire_st),
    .load_st  (load_st),
    .idle_st  (idle_st)
  );

  pgen_bcd_chain #(.DIGITS(NDIG)) u_chain (
    .clk            (clk),
    .rst_n          (rst_n),
    .load           (load_st),
    .load_digits    ({tens_in, units_in}),
    .dec            (fire_st),
    .digits         (cnt_digits),
    .all_zero       (all_zero),
    .chain_borrow_n (chain_borrow_n)
  );

  assign units_q = cnt_digits[DIGIT_W-1:0];
  assign tens_q  = cnt_digits[2*DIGIT_W-1:DIGIT_W];

  // fire_st only moves while clk is low, so this AND cannot glitch.
  assign pulse = fire_st & clk;
  assign done  = idle_st;

endmodule

// File: rtl/pgen_checker.sv
module pgen_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       fire_st,
  input logic       load_st,
  input logic       idle_st,
  input logic       all_zero,
  input logic       chain_borrow_n,
  input logic [3:0] tens_q,
  input logic [3:0] units_q
);

  int cnt_val;
  assign cnt_val = int'(tens_q) * 10 + int'(units_q);

  // R5: a fire slot is always followed by a quiet slot.
  a_r5_one_gap: assert property (@(negedge clk) disable iff (!rst_n)
    fire_st |=> !fire_st);

  // R8: loading is entered only from idle.
  a_r8_load_from_idle: assert property (@(negedge clk) disable iff (!rst_n)
    load_st |-> $past(idle_st));

  // R9: digits stay BCD.
  a_r9_digits_bcd: assert property (@(posedge clk) disable iff (!rst_n)
    (tens_q <= 4'd9) && (units_q <= 4'd9));

  // R9: each decrement lowers the value by one.
  a_r9_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    fire_st |=> (cnt_val == $past(cnt_val) - 1));

  // R9: the chain never borrows past its top digit.
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    chain_borrow_n);

  // R10: idle returns only with an empty count.
  a_r10_done_when_empty: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(idle_st) |-> all_zero);

endmodule

bind pulse_train_gen pgen_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fire_st        (fire_st),
  .load_st        (load_st),
  .idle_st        (idle_st),
  .all_zero       (all_zero),
  .chain_borrow_n (chain_borrow_n),
  .tens_q         (tens_q),
  .units_q        (units_q)
);

// File: tb/pulse_train_gen_tb_top.sv
`timescale 1ns/1ps
module pulse_train_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] tens_in = '0;
  logic [3:0] units_in = '0;
  logic       pulse, done;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  pulse_train_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .tens_in(tens_in), .units_in(units_in),
    .pulse(pulse), .done(done)
  );

  // {tens, units, expected pulse count}
  localparam int NVEC = 8;
  localparam logic [14:0] VEC [NVEC] = '{
    {4'd0,  4'd0,  7'd0},
    {4'd0,  4'd1,  7'd1},
    {4'd0,  4'd3,  7'd3},
    {4'd1,  4'd0,  7'd10},
    {4'd1,  4'd2,  7'd12},
    {4'd0,  4'd15, 7'd9},
    {4'd12, 4'd5,  7'd95},
    {4'd9,  4'd9,  7'd99}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Launch a burst and check each slot. With hold set, start stays high and
  // the digits are changed mid-burst (R8).
  task automatic run_case(input logic [3:0] t, input logic [3:0] u, input int n, input bit hold);
    int seen = 0;
    @(posedge clk); #5;
    tens_in = t; units_in = u; start = 1'b1;
    for (int j = 1; j <= 2*n + 2; j++) begin
      @(posedge clk); #5;
      if (!hold || j == 2*n + 1) start = 1'b0;
      if (hold && j == 2) begin tens_in = 4'd0; units_in = 4'd1; end
      if (pulse) seen++;
      // R2/R3/R5: pulse in even slots 2..2N only
      check(pulse == ((j % 2 == 0) && (j <= 2*n)), "R5 pulse slot", pulse, ((j % 2 == 0) && (j <= 2*n)));
      // R10/R6: done low until slot 2N+2
      check(done == (j == 2*n + 2), "R10 done timing", done, (j == 2*n + 2));
      #10;
      check(pulse == 1'b0, "R4 low phase quiet", pulse, 0);
    end
    check(seen == n, hold ? "R8 count kept" : "R3 pulse count", seen, n);
  endtask

  initial begin
    #4_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    #15;
    check(done == 1'b1, "R1 done in reset", done, 1);
    check(pulse == 1'b0, "R1 pulse in reset", pulse, 0);
    @(posedge clk); #5; rst_n = 1'b1;
    @(posedge clk); #5;
    check(done == 1'b1, "R1 done after reset", done, 1);

    // R2/R3/R6/R7: table walk
    for (int i = 0; i < NVEC; i++)
      run_case(VEC[i][14:11], VEC[i][10:7], int'(VEC[i][6:0]), 1'b0);

    // R8: start held and digits changed during a burst
    run_case(4'd0, 4'd4, 4, 1'b1);

    // R1: reset in mid-burst
    @(posedge clk); #5;
    tens_in = 4'd0; units_in = 4'd6; start = 1'b1;
    @(posedge clk); #5; start = 1'b0;
    repeat (3) @(posedge clk);
    #5; rst_n = 1'b0; #1;
    check(pulse == 1'b0, "R1 pulse on mid reset", pulse, 0);
    check(done == 1'b1, "R1 done on mid reset", done, 1);
    @(posedge clk); #5; rst_n = 1'b1;

    // R9: tens borrow after reset, units 0 with tens 2
    run_case(4'd2, 4'd0, 20, 1'b0);
    // R7: both digits above 9
    run_case(4'd15, 4'd10, 99, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule